// File: doc/BRIEF.md
# Delay-Line TDC Sample Decoder

This block turns the frozen state of a time-to-digital converter delay line into a binary count of the stages that the start edge had already crossed when the stop edge arrived. Each count step is one stage delay. The count is therefore the measured interval divided by one stage delay, rounded down. The delay line and its sampling flops sit outside the block. The block receives one parallel sample word per measurement, together with a strobe and a mode select.

Two chain types are supported, chosen by `inv_mode`:

- **Buffer chain** (`inv_mode` = 0). A plain buffer chain gives a thermometer word: crossed stages read 1 and stages not yet reached read 0.
- **Inverter chain** (`inv_mode` = 1). An inverting chain carries both edge polarities, so its raw sample alternates between 1 and 0. The point where the alternation slips its phase marks the extent of the start edge. The decoder re-inverts every odd-indexed stage, which turns this word into an ordinary thermometer word. Each step then stands for a single inverter delay, which is twice the resolution of a buffer chain of the same length.

After this correction, the count is the number of ones. This keeps the result meaningful when a few bits near the edge are out of order. A word with more than one descending edge raises an error flag. A word of all ones raises an overflow flag. The result is registered and appears one clock after the strobe.

Top module: `tdc_code_decoder`

## Requirements
- R1: With `inv_mode`=0 the corrected word equals `sample_code`. `count` equals the number of ones in `sample_code` (bit 0 is the stage nearest the start input).
- R2: With `inv_mode`=1, every odd bit index of `sample_code` is inverted and every even index is kept. `count` equals the number of ones in the resulting word, so the raw pattern with even bits 1 and odd bits 0 reads as full scale.
- R3: `bubble_err` is 1 exactly when the corrected word holds more than one index i with bit i = 1 and bit i+1 = 0. It is 0 otherwise.
- R4: A corrected word of all zeros gives `count`=0 and `overflow`=0. A corrected word of all ones gives `count`=STAGES and `overflow`=1. Any other word gives `overflow`=0.
- R5: `count_vld` is 1 in the cycle after a clock edge that sampled `sample_vld`=1, and 0 after an edge that sampled `sample_vld`=0. `count`, `bubble_err` and `overflow` reflect the word accepted at that edge.
- R6: While `sample_vld` is 0, `count`, `bubble_err` and `overflow` keep their values, whatever `sample_code` and `inv_mode` carry.
- R7: While `rst_n` is low, `count_vld`, `count`, `bubble_err` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decode clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Strobe: `sample_code` holds a new captured word |
| sample_code | input | STAGES | Raw sampled delay-line state, bit 0 nearest the start input |
| inv_mode | input | 1 | 0 = buffer chain, 1 = inverting chain |
| count_vld | output | 1 | Result strobe, one cycle after `sample_vld` |
| count | output | $clog2(STAGES+1) | Number of stages crossed by the start edge |
| bubble_err | output | 1 | Corrected word has more than one descending edge |
| overflow | output | 1 | Corrected word is all ones (edge ran off the line) |

## Verification
The eight-stage configuration is driven with every possible sample word in both modes. Clean thermometer words and clean alternating words confirm the count and the odd-bit correction: the same raw word must read differently in the two modes. Words with scattered bits separate a simple edge search from the ones-count rule and show when the error flag rises. The all-zero, all-one and full-scale alternating words pin down the overflow boundary. Idle cycles with a changing sample word and mode between strobes show that the result holds and the strobe drops.

// File: rtl/tdc_dec_pkg.sv
package tdc_dec_pkg;

  typedef enum logic {
    MODE_BUFFER   = 1'b0,
    MODE_INVERTER = 1'b1
  } chain_mode_e;

  // Odd stages of an inverting chain carry the opposite polarity.
  function automatic logic stage_is_flipped(input int idx);
    return (idx % 2) == 1;
  endfunction

endpackage

// File: rtl/tdc_phase_untwist.sv
module tdc_phase_untwist #(
  parameter int STAGES = 16
) (
  input  logic              flip_en,
  input  logic [STAGES-1:0] raw_word,
  output logic [STAGES-1:0] therm_word
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (tdc_dec_pkg::stage_is_flipped(g)) begin : g_flip
      assign therm_word[g] = raw_word[g] ^ flip_en;
    end else begin : g_keep
      assign therm_word[g] = raw_word[g];
    end
  end

endmodule

// File: rtl/tdc_ones_count.sv
module tdc_ones_count #(
  parameter int STAGES = 16,
  parameter int CW     = $clog2(STAGES + 1)
) (
  input  logic [STAGES-1:0] therm_word,
  output logic [CW-1:0]     ones
);

  always_comb begin
    ones = '0;
    for (int i = 0; i < STAGES; i++) begin
      ones = ones + CW'(therm_word[i]);
    end
  end

endmodule

// File: rtl/tdc_edge_check.sv
module tdc_edge_check #(
  parameter int STAGES = 16
) (
  input  logic [STAGES-1:0] therm_word,
  output logic              multi_fall,
  output logic              all_set
);

  localparam int FW = STAGES - 1;
  localparam logic [FW-1:0] ONE = FW'(1);

  logic [FW-1:0] falls;

  for (genvar g = 0; g < FW; g++) begin : g_fall
    assign falls[g] = therm_word[g] & ~therm_word[g+1];
  end

  // More than one bit set: clearing the lowest still leaves a bit.
  assign multi_fall = |(falls & (falls - ONE));
  assign all_set    = &therm_word;

endmodule

// File: rtl/tdc_code_decoder.sv
module tdc_code_decoder #(
  parameter  int STAGES = 16,
  localparam int CW     = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic [STAGES-1:0] sample_code,
  input  logic              inv_mode,
  output logic              count_vld,
  output logic [CW-1:0]     count,
  output logic              bubble_err,
  output logic              overflow
);

  import tdc_dec_pkg::*;

  chain_mode_e       mode;
  logic [STAGES-1:0] therm;
  logic [CW-1:0]     ones;
  logic              multi_fall;
  logic              all_set;

  logic              vld_d, vld_q;
  logic [CW-1:0]     cnt_d, cnt_q;
  logic              bub_d, bub_q;
  logic              ovf_d, ovf_q;

  assign mode = chain_mode_e'(inv_mode);

  tdc_phase_untwist #(.STAGES(STAGES)) u_untwist (
    .flip_en    (mode == MODE_INVERTER),
    .raw_word   (sample_code),
    .therm_word (therm)
  );

  tdc_ones_count #(.STAGES(STAGES), .CW(CW)) u_ones (
    .therm_word (therm),
    .ones       (ones)
  );

  tdc_edge_check #(.STAGES(STAGES)) u_edges (
    .therm_word (therm),
    .multi_fall (multi_fall),
    .all_set    (all_set)
  );

  // Next state: result registers load only on an accepted sample.
  always_comb begin
    vld_d = sample_vld;
    cnt_d = cnt_q;
    bub_d = bub_q;
    ovf_d = ovf_q;
    if (sample_vld) begin
      cnt_d = ones;
      bub_d = multi_fall;
      ovf_d = all_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
      bub_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      cnt_q <= cnt_d;
      bub_q <= bub_d;
      ovf_q <= ovf_d;
    end
  end

  assign count_vld  = vld_q;
  assign count      = cnt_q;
  assign bubble_err = bub_q;
  assign overflow   = ovf_q;

endmodule

// File: rtl/tdc_code_decoder_chk.sv
module tdc_code_decoder_chk #(
  parameter  int STAGES = 16,
  localparam int CW     = $clog2(STAGES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_vld,
  input logic [STAGES-1:0] sample_code,
  input logic              inv_mode,
  input logic              count_vld,
  input logic [CW-1:0]     count,
  input logic              bubble_err,
  input logic              overflow
);

  logic [STAGES-1:0] even_high;
  always_comb begin
    for (int i = 0; i < STAGES; i++) even_high[i] = (i % 2) == 0;
  end

  assert_vld_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> count_vld);

  assert_vld_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> !count_vld);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> ($stable(count) && $stable(bubble_err) && $stable(overflow)));

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(STAGES));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (count == CW'(STAGES)));

  assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !inv_mode && sample_code == '0) |=> (count == '0 && !overflow));

  assert_bubble_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_err |-> (count >= CW'(2) && count <= CW'(STAGES - 2) && !overflow));

  assert_alt_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && inv_mode && sample_code == even_high) |=> overflow);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R7: assert (!count_vld && count == '0 && !bubble_err && !overflow);
    end
  end

endmodule

bind tdc_code_decoder tdc_code_decoder_chk #(.STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_vld  (sample_vld),
  .sample_code (sample_code),
  .inv_mode    (inv_mode),
  .count_vld   (count_vld),
  .count       (count),
  .bubble_err  (bubble_err),
  .overflow    (overflow)
);

// File: tb/tdc_code_decoder_test.sv
module tdc_code_decoder_test;

  localparam int ST = 8;
  localparam int CW = $clog2(ST + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sample_vld;
  logic [ST-1:0] sample_code;
  logic          inv_mode;
  logic          count_vld;
  logic [CW-1:0] count;
  logic          bubble_err;
  logic          overflow;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  tdc_code_decoder #(.STAGES(ST)) uut (
    .clk, .rst_n, .sample_vld, .sample_code, .inv_mode,
    .count_vld, .count, .bubble_err, .overflow
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int e_cnt, e_bub, e_ovf, falls, k;
    logic [ST-1:0] corr;
    rst_n = 1'b0; sample_vld = 1'b1; sample_code = '1; inv_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", "count_vld", count_vld, 0);
    check("R7", "count", count, 0);
    check("R7", "bubble_err", bubble_err, 0);
    check("R7", "overflow", overflow, 0);
    rst_n = 1'b1;
    sample_vld = 1'b0;
    @(negedge clk);
    k = 0;
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < (1 << ST); c++) begin
        sample_vld  = 1'b1;
        inv_mode    = m[0];
        sample_code = c[ST-1:0];
        corr = sample_code ^ (m[0] ? 8'hAA : 8'h00);
        e_cnt = 0;
        for (int i = 0; i < ST; i++) e_cnt += corr[i];
        falls = 0;
        for (int i = 0; i < ST - 1; i++) falls += (corr[i] && !corr[i+1]) ? 1 : 0;
        e_bub = falls > 1 ? 1 : 0;
        e_ovf = (corr == '1) ? 1 : 0;
        @(negedge clk);
        check("R5", "count_vld", count_vld, 1);
        check(m ? "R2" : "R1", "count", count, e_cnt);
        check("R3", "bubble_err", bubble_err, e_bub);
        check("R4", "overflow", overflow, e_ovf);
        if (corr == '0) check("R4", "zero word count", count, 0);
        if (corr == '1) check("R4", "full word count", count, ST);
        k++;
        if (k % 3 == 0) begin
          // idle cycle: change inputs without the strobe
          sample_vld  = 1'b0;
          sample_code = ~sample_code;
          inv_mode    = ~inv_mode;
          @(negedge clk);
          check("R5", "count_vld idle", count_vld, 0);
          check("R6", "count held", count, e_cnt);
          check("R6", "bubble held", bubble_err, e_bub);
          check("R6", "overflow held", overflow, e_ovf);
        end
      end
    end
    // same raw alternating word, read in both modes
    sample_vld = 1'b1; inv_mode = 1'b0; sample_code = 8'h55;
    @(negedge clk);
    check("R1", "buffer read of 0x55", count, 4);
    check("R3", "buffer read of 0x55 bubble", bubble_err, 1);
    inv_mode = 1'b1;
    @(negedge clk);
    check("R2", "inverter read of 0x55", count, ST);
    check("R4", "inverter read of 0x55 overflow", overflow, 1);
    sample_vld = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule